// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external interrupt pins and turns their activity into four grouped interrupt requests. Every pin is brought into the clock domain through a two-stage synchroniser, then compared against a trigger condition. The condition is chosen per pair of pins: low level, high level, falling edge, rising edge or either edge. A qualifying event latches a sticky pending bit for that pin. Software clears a pending bit by writing 1 to it.

A per-pin mask decides whether a pending pin may raise its group request. The mask never stops the pending bit from latching. The four request outputs cover uneven ranges of pins: 0 to 3, 4 to 11, 12 to 19 and 20 to 27. An interrupt handler reads the pending register to find which pin in its group needs service.

Access goes through a small synchronous register bus. A write takes effect at the clock edge on which it is presented. Read data is a combinational function of the address and the register contents.

Top module: `extirq_grp_ctrl`

## Requirements
- R1: While reset is held and right after it, both trigger-configuration registers read 0, the mask register reads 0x0FFFFFFF, the pending register reads 0 and all four group outputs are low.
- R2: The register map is: address 0 holds the triggers of lines 0 to 15, address 1 those of lines 16 to 27, address 2 the mask and address 3 the pending bits. Line n (taken relative to the first line of its register) uses the 3-bit field at bit (n/2)*4. Lines 2k and 2k+1 therefore share one field, and bit 3 of each nibble reads 0.
- R3: Bits that would belong to a line above 27 cannot be written and read 0. These are bits 24 to 31 of address 1 and bits 28 to 31 of the mask and pending registers.
- R4: Trigger code 000 selects low level and 001 selects high level. While the chosen level is present, the pending bit is set again on every cycle, even just after a clear.
- R5: Trigger codes 01x select the falling edge, 10x the rising edge and 11x both edges. Each qualifying edge sets the pending bit once, and a cleared bit stays clear until the next edge.
- R6: A pin change made between clock edges shows in the pending register after the third rising clock edge that follows it, and not before.
- R7: A mask bit of 1 blocks the line from its group output, and 0 lets it through. A masked line still latches its pending bit.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves the bit as it was.
- R9: When an event and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: Output 0 is the OR of the pending and unmasked lines 0 to 3. Output 1 covers lines 4 to 11, output 2 lines 12 to 19 and output 3 lines 20 to 27.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_in | input | 28 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| grp_irq | output | 4 | Group interrupt requests, one per line range |

## Verification
The hardest case to reach from the ports is an edge event and a write-1 clear landing on the same pending bit in the same clock cycle. Two synchroniser stages sit between the pin and the event, so the bench moves the pin and counts two falling edges. It then presents the clear so that it lands on the exact edge where the event registers. The same cycle counting is used to sample the pending register one edge before and one edge at the moment of latching. Every trigger code is also exercised at the boundaries of the register split and of each group range.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

   typedef enum logic [1:0] {
      RA_TRIG_LO = 2'd0,
      RA_TRIG_HI = 2'd1,
      RA_MASK    = 2'd2,
      RA_PEND    = 2'd3
   } reg_addr_e;

   localparam int TRIG_W   = 3;
   localparam int NIBBLE_W = 4;
   localparam int N_GROUPS = 4;

   localparam int GRP_FIRST [N_GROUPS] = '{0, 4, 12, 20};
   localparam int GRP_LAST  [N_GROUPS] = '{3, 11, 19, 27};

   function automatic logic [31:0] trig_field_bits(input int n_lines);
      logic [31:0] m;
      m = '0;
      for (int k = 0; k < (n_lines + 1) / 2; k++) begin
         m[k*NIBBLE_W +: TRIG_W] = '1;
      end
      return m;
   endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync (
   input  logic clk,
   input  logic rst,
   input  logic pin_i,
   output logic lvl_o,
   output logic prev_o
);
   logic meta_q, lvl_q, prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         meta_q <= 1'b0;
         lvl_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         meta_q <= pin_i;
         lvl_q  <= meta_q;
         prev_q <= lvl_q;
      end
   end

   assign lvl_o  = lvl_q;
   assign prev_o = prev_q;

   // R6
   sync_stage_chk: assert property (@(posedge clk) disable iff (rst)
      lvl_q == $past(meta_q));

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
   import extirq_pkg::*;
(
   input  logic [TRIG_W-1:0] mode_i,
   input  logic              lvl_i,
   input  logic              prev_i,
   output logic              evt_o
);
   always_comb begin
      unique case (mode_i[2:1])
         2'b00:   evt_o = mode_i[0] ? lvl_i : ~lvl_i;
         2'b01:   evt_o = prev_i & ~lvl_i;
         2'b10:   evt_o = ~prev_i & lvl_i;
         default: evt_o = prev_i ^ lvl_i;
      endcase
   end
endmodule

// File: rtl/extirq_group.sv
module extirq_group
   import extirq_pkg::*;
#(
   parameter int NUM_LINES = 28
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] pend_i,
   input  logic [NUM_LINES-1:0] mask_i,
   output logic [N_GROUPS-1:0]  grp_o
);
   logic [NUM_LINES-1:0] live;
   assign live = pend_i & ~mask_i;

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      localparam int LO = GRP_FIRST[g];
      localparam int HI = GRP_LAST[g];
      if (HI >= NUM_LINES || LO > HI) begin : g_bad
         $error("group range outside line count");
      end
      assign grp_o[g] = |live[HI:LO];
   end

   // R10
   grp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (&mask_i) |-> (grp_o == '0));

endmodule

// File: rtl/extirq_grp_ctrl.sv
module extirq_grp_ctrl
   import extirq_pkg::*;
#(
   parameter int NUM_LINES = 28,
   parameter int SPLIT     = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LINES-1:0] ext_in,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [N_GROUPS-1:0]  grp_irq
);
   localparam int LINES_LO = SPLIT;
   localparam int LINES_HI = NUM_LINES - SPLIT;
   localparam logic [DATA_W-1:0] WMASK_LO = DATA_W'(trig_field_bits(LINES_LO));
   localparam logic [DATA_W-1:0] WMASK_HI = DATA_W'(trig_field_bits(LINES_HI));

   if (DATA_W != 32) begin : g_bad_width
      $error("register width must be 32");
   end
   if (NUM_LINES >= DATA_W || SPLIT >= NUM_LINES) begin : g_bad_lines
      $error("line count does not fit the register layout");
   end
   if (((LINES_HI + 1) / 2) * NIBBLE_W > DATA_W || (SPLIT / 2) * NIBBLE_W > DATA_W) begin : g_bad_split
      $error("trigger fields overflow a register");
   end

   logic [DATA_W-1:0]    trig_lo_q, trig_hi_q;
   logic [NUM_LINES-1:0] mask_q, pend_q;
   logic [NUM_LINES-1:0] line_lvl, line_prev, line_evt;
   logic [NUM_LINES-1:0] clr_bits;
   logic                 wr_lo, wr_hi, wr_mask, wr_pend;

   assign wr_lo   = bus_sel && bus_wr && (bus_addr == RA_TRIG_LO);
   assign wr_hi   = bus_sel && bus_wr && (bus_addr == RA_TRIG_HI);
   assign wr_mask = bus_sel && bus_wr && (bus_addr == RA_MASK);
   assign wr_pend = bus_sel && bus_wr && (bus_addr == RA_PEND);
   assign clr_bits = wr_pend ? bus_wdata[NUM_LINES-1:0] : '0;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic [TRIG_W-1:0] mode;
      if (i < SPLIT) begin : g_lo
         assign mode = trig_lo_q[(i/2)*NIBBLE_W +: TRIG_W];
      end else begin : g_hi
         assign mode = trig_hi_q[((i-SPLIT)/2)*NIBBLE_W +: TRIG_W];
      end

      extirq_sync i_sync (
         .clk    (clk),
         .rst    (rst),
         .pin_i  (ext_in[i]),
         .lvl_o  (line_lvl[i]),
         .prev_o (line_prev[i])
      );

      extirq_detect i_detect (
         .mode_i (mode),
         .lvl_i  (line_lvl[i]),
         .prev_i (line_prev[i]),
         .evt_o  (line_evt[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         trig_lo_q <= '0;
         trig_hi_q <= '0;
         mask_q    <= '1;
         pend_q    <= '0;
      end else begin
         if (wr_lo)   trig_lo_q <= bus_wdata & WMASK_LO;
         if (wr_hi)   trig_hi_q <= bus_wdata & WMASK_HI;
         if (wr_mask) mask_q    <= bus_wdata[NUM_LINES-1:0];
         pend_q <= (pend_q & ~clr_bits) | line_evt;
      end
   end

   always_comb begin
      unique case (bus_addr)
         RA_TRIG_LO: bus_rdata = trig_lo_q;
         RA_TRIG_HI: bus_rdata = trig_hi_q;
         RA_MASK:    bus_rdata = {{(DATA_W-NUM_LINES){1'b0}}, mask_q};
         default:    bus_rdata = {{(DATA_W-NUM_LINES){1'b0}}, pend_q};
      endcase
   end

   extirq_group #(.NUM_LINES(NUM_LINES)) i_group (
      .clk    (clk),
      .rst    (rst),
      .pend_i (pend_q),
      .mask_i (mask_q),
      .grp_o  (grp_irq)
   );

   // R8
   pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
      wr_pend |=> ((pend_q & $past(bus_wdata[NUM_LINES-1:0] & ~line_evt)) == '0));

   // R9
   event_wins_chk: assert property (@(posedge clk) disable iff (rst)
      wr_pend |=> ((pend_q & $past(line_evt)) == $past(line_evt)));

   // R7
   latch_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (|(line_evt & mask_q)) |=> ((pend_q & $past(line_evt & mask_q)) == $past(line_evt & mask_q)));

   // R3
   mask_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_mask |=> (mask_q == $past(bus_wdata[NUM_LINES-1:0])));

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: tb/test_extirq_grp_ctrl.sv
module test_extirq_grp_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [27:0] ext_in = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  grp_irq;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   extirq_grp_ctrl i_extirq_grp_ctrl (
      .clk(clk), .rst(rst), .ext_in(ext_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp_irq(grp_irq)
   );

   // {line[4:0], trig[2:0], before, after, expected pending}
   localparam logic [10:0] VEC [11] = '{
      {5'd0,  3'b010, 1'b1, 1'b0, 1'b1},
      {5'd1,  3'b010, 1'b0, 1'b1, 1'b0},
      {5'd5,  3'b100, 1'b0, 1'b1, 1'b1},
      {5'd6,  3'b101, 1'b1, 1'b0, 1'b0},
      {5'd12, 3'b110, 1'b0, 1'b1, 1'b1},
      {5'd13, 3'b111, 1'b1, 1'b0, 1'b1},
      {5'd19, 3'b001, 1'b0, 1'b1, 1'b1},
      {5'd20, 3'b000, 1'b1, 1'b0, 1'b1},
      {5'd27, 3'b100, 1'b1, 1'b1, 1'b0},
      {5'd16, 3'b001, 1'b0, 1'b0, 1'b0},
      {5'd23, 3'b011, 1'b1, 1'b0, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   function automatic int group_of(input int ln);
      if (ln < 4) return 0;
      if (ln < 12) return 1;
      if (ln < 20) return 2;
      return 3;
   endfunction

   initial begin
      #(200000 * 20);
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      idle(3);
      // R1 reset state, read while reset is held
      bus_read(2'd0, rd); check("R1 trig lo", rd, 32'h0);
      bus_read(2'd1, rd); check("R1 trig hi", rd, 32'h0);
      bus_read(2'd2, rd); check("R1 mask", rd, 32'h0FFF_FFFF);
      bus_read(2'd3, rd); check("R1 pend", rd, 32'h0);
      check("R1 groups", {28'h0, grp_irq}, 32'h0);
      rst = 1'b0;
      idle(1);
      check("R1 groups after release", {28'h0, grp_irq}, 32'h0);

      // table walk: R2 field placement, R4 R5 trigger codes, R10 grouping
      for (int v = 0; v < 11; v++) begin
         int ln, rel, g;
         logic [2:0] md;
         logic v0, v1, ex;
         ln = int'(VEC[v][10:6]); md = VEC[v][5:3];
         v0 = VEC[v][2]; v1 = VEC[v][1]; ex = VEC[v][0];
         rel = (ln < 16) ? ln : ln - 16;
         g = group_of(ln);
         bus_write((ln < 16) ? 2'd0 : 2'd1, 32'(md) << ((rel / 2) * 4));
         bus_write(2'd2, ~(32'd1 << ln));
         ext_in[ln] = v0;
         idle(5);
         bus_write(2'd3, 32'hFFFF_FFFF);
         ext_in[ln] = v1;
         idle(5);
         bus_read(2'd3, rd);
         check($sformatf("R4/R5 line %0d pending", ln), {31'h0, rd[ln]}, {31'h0, ex});
         check($sformatf("R10 line %0d group", ln), {28'h0, grp_irq}, {28'h0, 4'(ex) << g});
      end

      // R6 latency and R9 event against clear in the same cycle
      bus_write(2'd2, 32'h0FFF_FFFF);
      bus_write(2'd0, 32'h0000_0004);     // lines 0,1 rising edge
      ext_in[0] = 1'b0;
      idle(4);
      bus_write(2'd3, 32'hFFFF_FFFF);
      ext_in[0] = 1'b1;
      idle(1);
      bus_read(2'd3, rd); check("R6 after 1 edge", {31'h0, rd[0]}, 32'h0);
      idle(1);
      bus_read(2'd3, rd); check("R6 after 2 edges", {31'h0, rd[0]}, 32'h0);
      idle(1);
      bus_read(2'd3, rd); check("R6 after 3 edges", {31'h0, rd[0]}, 32'h1);

      ext_in[0] = 1'b0;
      idle(4);
      bus_write(2'd3, 32'hFFFF_FFFF);
      ext_in[0] = 1'b1;
      idle(2);
      bus_write(2'd3, 32'hFFFF_FFFF);     // lands on the event edge
      bus_read(2'd3, rd); check("R9 event beats clear", {31'h0, rd[0]}, 32'h1);

      // R8 write 0 keeps, write 1 clears; R5 no re-set without an edge
      bus_write(2'd3, 32'h0);
      bus_read(2'd3, rd); check("R8 write 0 keeps", {31'h0, rd[0]}, 32'h1);
      bus_write(2'd3, 32'h1);
      idle(3);
      bus_read(2'd3, rd); check("R5 edge sets once", {31'h0, rd[0]}, 32'h0);

      // R4 level persists across clear; R7 masked latch then unmask
      bus_write(2'd0, 32'h0000_0010);     // lines 2,3 high level
      ext_in[2] = 1'b1;
      idle(5);
      bus_write(2'd3, 32'h0000_0004);
      bus_read(2'd3, rd); check("R4 level re-sets", {31'h0, rd[2]}, 32'h1);
      check("R7 masked no group", {28'h0, grp_irq}, 32'h0);
      bus_write(2'd2, 32'h0FFF_FFFB);
      check("R7 unmasked group 0", {28'h0, grp_irq}, 32'h1);
      bus_write(2'd2, 32'h0FFF_FFFF);
      ext_in[2] = 1'b0;

      // R2 pair sharing: lines 6 and 7 set by one field
      bus_write(2'd0, 32'h0000_4000);
      ext_in[6] = 1'b0; ext_in[7] = 1'b0;
      idle(4);
      bus_write(2'd3, 32'hFFFF_FFFF);
      ext_in[6] = 1'b1; ext_in[7] = 1'b1;
      idle(4);
      bus_read(2'd3, rd); check("R2 shared field", {30'h0, rd[7:6]}, 32'h3);

      // R2 and R3 readback of writable bits
      bus_write(2'd0, 32'hFFFF_FFFF);
      bus_read(2'd0, rd); check("R2 nibble bit 3 unused", rd, 32'h7777_7777);
      bus_write(2'd1, 32'hFFFF_FFFF);
      bus_read(2'd1, rd); check("R3 trig hi above 27", rd, 32'h0077_7777);
      bus_write(2'd2, 32'hFFFF_FFFF);
      bus_read(2'd2, rd); check("R3 mask above 27", rd, 32'h0FFF_FFFF);
      bus_read(2'd3, rd); check("R3 pend above 27", rd & 32'hF000_0000, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule